// File: doc/BRIEF.md
# Tri-Port Latched Bus Exchanger

This block connects one host-side data port (A) with two memory-side data ports (1B and 2B). It is meant for even/odd memory interleaving, where the host writes to one bank while the other bank is read, and for address multiplexing, where two memory-side values are parked and then handed to the host in turn. Four independent gated holding stages move the data. Two of them carry A outward, one toward each B port. The other two carry 1B and 2B back toward A. A return-select input chooses which inbound stage drives A.

Each bidirectional port appears as three signals: an input bus, an output bus and an active-high drive flag. An integrating wrapper can merge them into a tri-state pad. The output bus always shows the content of its stage. The drive flag is the inverse of that port's active-low output enable, and it alone decides whether the port is driven or left floating.

Every stage works on the block clock. While a stage's gate is high, its output follows its input combinationally, and the stage samples that input at each rising clock edge. While the gate is low, the output shows the value sampled at the last rising edge on which the gate was high. A synchronous active-high reset clears all four stored values to zero.

Top module: `bus_exchanger`

## Requirements
- R1: A clock edge with `rst` high clears all four stored values to zero. After reset, with every gate low, `a_out`, `b1_out` and `b2_out` read 0 for both settings of `ret_sel`.
- R2: While `a2b1_le` is high, `b1_out` equals `a_in` in the same cycle. While `a2b2_le` is high, `b2_out` equals `a_in`.
- R3: After `a2b1_le` (or `a2b2_le`) goes low, `b1_out` (or `b2_out`) holds the `a_in` value sampled at the last rising edge on which that gate was high, and later changes on `a_in` have no effect on it.
- R4: While `b12a_le` is high and `ret_sel` is 1, `a_out` equals `b1_in`. While `b22a_le` is high and `ret_sel` is 0, `a_out` equals `b2_in`.
- R5: After `b12a_le` (or `b22a_le`) goes low, the matching inbound stage holds the `b1_in` (or `b2_in`) value sampled at the last rising edge on which its gate was high, and later changes on that input have no effect on it.
- R6: With both inbound gates low, `ret_sel` = 1 puts the held 1B value on `a_out` and `ret_sel` = 0 puts the held 2B value on `a_out`. Switching `ret_sel` changes `a_out` in the same cycle and leaves both stored values unchanged.
- R7: `a_drive`, `b1_drive` and `b2_drive` are each the inverse of `a_oe_n`, `b1_oe_n` and `b2_oe_n` in the same cycle, independently of one another. A flag of 0 means the port is not driven.
- R8: 1B can drive outward (`b1_oe_n` = 0, `a2b1_le` = 1) while 2B is undriven and its data flows through to A (`b2_oe_n` = 1, `b22a_le` = 1, `ret_sel` = 0), in the same cycle.
- R9: With both outbound gates high, one `a_in` value reaches `b1_out` and `b2_out` together, and both ports keep it after both gates drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; stages sample on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the stored values |
| a_in | input | 12 | Data arriving on the host port |
| a_out | output | 12 | Data presented toward the host port |
| a_drive | output | 1 | High when the host port is driven |
| a_oe_n | input | 1 | Active-low output enable of the host port |
| b1_in | input | 12 | Data arriving on memory port 1B |
| b1_out | output | 12 | Data presented toward memory port 1B |
| b1_drive | output | 1 | High when port 1B is driven |
| b1_oe_n | input | 1 | Active-low output enable of port 1B |
| b2_in | input | 12 | Data arriving on memory port 2B |
| b2_out | output | 12 | Data presented toward memory port 2B |
| b2_drive | output | 1 | High when port 2B is driven |
| b2_oe_n | input | 1 | Active-low output enable of port 2B |
| a2b1_le | input | 1 | Gate of the A-to-1B stage |
| a2b2_le | input | 1 | Gate of the A-to-2B stage |
| b12a_le | input | 1 | Gate of the 1B-to-A stage |
| b22a_le | input | 1 | Gate of the 2B-to-A stage |
| ret_sel | input | 1 | 1 routes the 1B return to A, 0 routes the 2B return |

## Verification
Several properties are checked on every cycle. Open gates pass data end to end, from an input pin through the stage and the return selector to an output pin. A closed stage keeps its output stable and shows what it sampled on the last open edge. Reset leaves zeros behind, and the number of driven ports matches the number of asserted enables. Some behaviour only shows up in the bench's scenarios: which exact value a stage keeps when its gate closes between edges, that later input activity leaves parked values alone, `ret_sel` switching back and forth between two different parked values, and the mixed case where one B port drives while the other feeds A.

// File: rtl/bx_pkg.sv
package bx_pkg;

    localparam int BX_DATA_W = 12;
    localparam int BX_B_PORTS = 2;

    typedef enum logic {
        RET_FROM_2B = 1'b0,
        RET_FROM_1B = 1'b1
    } ret_src_e;

    function automatic logic drive_from_oe(input logic oe_n);
        return ~oe_n;
    endfunction

endpackage

// File: rtl/bx_latch.sv
module bx_latch #(
    parameter int W = bx_pkg::BX_DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         gate,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (gate) begin
            held_q <= d;
        end
    end

    assign q = gate ? d : held_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!gate && $past(!gate) && $past(!rst)) |-> $stable(q)); // R3 R5

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        gate |=> (gate || q == $past(d))); // R3 R5

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !gate) |-> q == '0); // R1

endmodule

// File: rtl/bx_ret_mux.sv
module bx_ret_mux #(
    parameter int W = bx_pkg::BX_DATA_W
) (
    input  bx_pkg::ret_src_e sel,
    input  logic [W-1:0]     from_1b,
    input  logic [W-1:0]     from_2b,
    output logic [W-1:0]     y
);

    always_comb begin
        unique case (sel)
            bx_pkg::RET_FROM_1B: y = from_1b;
            bx_pkg::RET_FROM_2B: y = from_2b;
            default:             y = from_2b;
        endcase
    end

endmodule

// File: rtl/bx_port_drv.sv
module bx_port_drv #(
    parameter int W = bx_pkg::BX_DATA_W
) (
    input  logic         oe_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] out,
    output logic         drive
);

    assign out   = d;
    assign drive = bx_pkg::drive_from_oe(oe_n);

endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
    parameter int W = bx_pkg::BX_DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    input  logic         a_oe_n,
    input  logic [W-1:0] b1_in,
    output logic [W-1:0] b1_out,
    output logic         b1_drive,
    input  logic         b1_oe_n,
    input  logic [W-1:0] b2_in,
    output logic [W-1:0] b2_out,
    output logic         b2_drive,
    input  logic         b2_oe_n,
    input  logic         a2b1_le,
    input  logic         a2b2_le,
    input  logic         b12a_le,
    input  logic         b22a_le,
    input  logic         ret_sel
);
    import bx_pkg::*;

    localparam int NB = BX_B_PORTS;

    logic [W-1:0] b_in_arr  [NB];
    logic [W-1:0] b_out_arr [NB];
    logic [W-1:0] out_lat   [NB];
    logic [W-1:0] ret_lat   [NB];
    logic         out_gate  [NB];
    logic         ret_gate  [NB];
    logic         b_oe_arr  [NB];
    logic         b_drv_arr [NB];
    logic [W-1:0] a_sel;
    ret_src_e     ret_src;

    assign b_in_arr[0] = b1_in;
    assign b_in_arr[1] = b2_in;
    assign out_gate[0] = a2b1_le;
    assign out_gate[1] = a2b2_le;
    assign ret_gate[0] = b12a_le;
    assign ret_gate[1] = b22a_le;
    assign b_oe_arr[0] = b1_oe_n;
    assign b_oe_arr[1] = b2_oe_n;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_bport
            bx_latch #(.W(W)) i_outbound (
                .clk  (clk),
                .rst  (rst),
                .gate (out_gate[g]),
                .d    (a_in),
                .q    (out_lat[g])
            );

            bx_latch #(.W(W)) i_inbound (
                .clk  (clk),
                .rst  (rst),
                .gate (ret_gate[g]),
                .d    (b_in_arr[g]),
                .q    (ret_lat[g])
            );

            bx_port_drv #(.W(W)) i_bdrv (
                .oe_n  (b_oe_arr[g]),
                .d     (out_lat[g]),
                .out   (b_out_arr[g]),
                .drive (b_drv_arr[g])
            );
        end
    endgenerate

    assign ret_src = ret_src_e'(ret_sel);

    bx_ret_mux #(.W(W)) i_ret_mux (
        .sel     (ret_src),
        .from_1b (ret_lat[0]),
        .from_2b (ret_lat[1]),
        .y       (a_sel)
    );

    bx_port_drv #(.W(W)) i_adrv (
        .oe_n  (a_oe_n),
        .d     (a_sel),
        .out   (a_out),
        .drive (a_drive)
    );

    assign b1_out   = b_out_arr[0];
    assign b2_out   = b_out_arr[1];
    assign b1_drive = b_drv_arr[0];
    assign b2_drive = b_drv_arr[1];

    AST_FLOW_TO_1B: assert property (@(posedge clk) disable iff (rst)
        a2b1_le |-> b1_out == a_in); // R2

    AST_FLOW_TO_2B: assert property (@(posedge clk) disable iff (rst)
        a2b2_le |-> b2_out == a_in); // R2

    AST_RETURN_1B: assert property (@(posedge clk) disable iff (rst)
        (ret_sel && b12a_le) |-> a_out == b1_in); // R4

    AST_RETURN_2B: assert property (@(posedge clk) disable iff (rst)
        (!ret_sel && b22a_le) |-> a_out == b2_in); // R4

    AST_DRIVE_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones({a_drive, b1_drive, b2_drive}) ==
        3 - $countones({a_oe_n, b1_oe_n, b2_oe_n})); // R7

    AST_MIXED_DIR: assert property (@(posedge clk) disable iff (rst)
        (!b1_oe_n && b2_oe_n && a2b1_le && b22a_le && !ret_sel) |->
        (b1_drive && !b2_drive && b1_out == a_in && a_out == b2_in)); // R8

endmodule

// File: tb/test_bus_exchanger.sv
module test_bus_exchanger;
    localparam int W = bx_pkg::BX_DATA_W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         a_oe_n = 1'b0, b1_oe_n = 1'b0, b2_oe_n = 1'b0;
    logic         a2b1_le = 1'b0, a2b2_le = 1'b0, b12a_le = 1'b0, b22a_le = 1'b0;
    logic         ret_sel = 1'b0;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_drive, b1_drive, b2_drive;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    logic [W-1:0] m_to1 = '0, m_to2 = '0, m_from1 = '0, m_from2 = '0;

    always #10 clk = ~clk;

    bus_exchanger #(.W(W)) i_bus_exchanger (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive), .a_oe_n(a_oe_n),
        .b1_in(b1_in), .b1_out(b1_out), .b1_drive(b1_drive), .b1_oe_n(b1_oe_n),
        .b2_in(b2_in), .b2_out(b2_out), .b2_drive(b2_drive), .b2_oe_n(b2_oe_n),
        .a2b1_le(a2b1_le), .a2b2_le(a2b2_le), .b12a_le(b12a_le), .b22a_le(b22a_le),
        .ret_sel(ret_sel)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_to1 = '0; m_to2 = '0; m_from1 = '0; m_from2 = '0;
        end else begin
            if (a2b1_le) m_to1 = a_in;
            if (a2b2_le) m_to2 = a_in;
            if (b12a_le) m_from1 = b1_in;
            if (b22a_le) m_from2 = b2_in;
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // reference comparison on every cycle, 2 ns before the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #8;
            if (!rst) begin
                chk("R2 R3 b1_out", b1_out, a2b1_le ? a_in : m_to1);
                chk("R2 R3 b2_out", b2_out, a2b2_le ? a_in : m_to2);
                chk("R4 R5 R6 a_out", a_out,
                    ret_sel ? (b12a_le ? b1_in : m_from1) : (b22a_le ? b2_in : m_from2));
                chk("R7 drives", {9'd0, a_drive, b1_drive, b2_drive},
                    {9'd0, !a_oe_n, !b1_oe_n, !b2_oe_n});
            end
        end
    end

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    task automatic settle;
        #6;
    endtask

    initial begin
        repeat (3) step;
        rst = 1'b0;
        step; settle;
        // R1: everything reads zero after reset
        chk("R1 b1_out", b1_out, 12'h000);
        chk("R1 b2_out", b2_out, 12'h000);
        chk("R1 a_out sel0", a_out, 12'h000);
        ret_sel = 1'b1; #1;
        chk("R1 a_out sel1", a_out, 12'h000);

        // R2: outbound 1B open
        step; a_in = 12'h5A5; a2b1_le = 1'b1; settle;
        chk("R2 b1 follows", b1_out, 12'h5A5);
        chk("R2 b2 closed stays", b2_out, 12'h000);
        step; a_in = 12'h123; settle;
        chk("R2 b1 follows new", b1_out, 12'h123);

        // R3: close and disturb input
        step; a2b1_le = 1'b0; a_in = 12'hFFF; settle;
        chk("R3 b1 holds", b1_out, 12'h123);
        step; a_in = 12'h0F0; settle;
        chk("R3 b1 still holds", b1_out, 12'h123);

        // R9: broadcast to both
        step; a_in = 12'hABC; a2b1_le = 1'b1; a2b2_le = 1'b1; settle;
        chk("R9 b1 bcast", b1_out, 12'hABC);
        chk("R9 b2 bcast", b2_out, 12'hABC);
        step; a2b1_le = 1'b0; a2b2_le = 1'b0; a_in = 12'h111; settle;
        chk("R9 b1 kept", b1_out, 12'hABC);
        chk("R9 b2 kept", b2_out, 12'hABC);

        // R4 / R5: inbound 1B
        step; ret_sel = 1'b1; b1_in = 12'h321; b12a_le = 1'b1; settle;
        chk("R4 a from 1b", a_out, 12'h321);
        step; b12a_le = 1'b0; b1_in = 12'h777; settle;
        chk("R5 1b held", a_out, 12'h321);

        // R4 / R5: inbound 2B
        step; ret_sel = 1'b0; b2_in = 12'h654; b22a_le = 1'b1; settle;
        chk("R4 a from 2b", a_out, 12'h654);
        step; b22a_le = 1'b0; b2_in = 12'h999; settle;
        chk("R5 2b held", a_out, 12'h654);

        // R6: toggle select between parked values
        step; ret_sel = 1'b1; settle;
        chk("R6 sel1", a_out, 12'h321);
        step; ret_sel = 1'b0; settle;
        chk("R6 sel0", a_out, 12'h654);
        step; ret_sel = 1'b1; settle;
        chk("R6 sel1 again", a_out, 12'h321);

        // R7: enables independent
        step; a_oe_n = 1'b1; b1_oe_n = 1'b0; b2_oe_n = 1'b1; settle;
        chk("R7 a undriven", {11'd0, a_drive}, 12'd0);
        chk("R7 b1 driven", {11'd0, b1_drive}, 12'd1);
        chk("R7 b2 undriven", {11'd0, b2_drive}, 12'd0);
        step; a_oe_n = 1'b0; b1_oe_n = 1'b1; b2_oe_n = 1'b0; settle;
        chk("R7 pattern2", {9'd0, a_drive, b1_drive, b2_drive}, 12'b101);

        // R8: 1B drives out while 2B feeds A
        step; b1_oe_n = 1'b0; b2_oe_n = 1'b1; ret_sel = 1'b0;
        a2b1_le = 1'b1; b22a_le = 1'b1; a_in = 12'h2C3; b2_in = 12'h4D5; settle;
        chk("R8 b1 out", b1_out, 12'h2C3);
        chk("R8 a from 2b", a_out, 12'h4D5);
        chk("R8 drives", {9'd0, a_drive, b1_drive, b2_drive}, 12'b110);
        step; a2b1_le = 1'b0; b22a_le = 1'b0; a_in = 12'h000; b2_in = 12'h000; settle;
        chk("R8 b1 kept", b1_out, 12'h2C3);
        chk("R8 2b kept", a_out, 12'h4D5);

        // R1: reset again clears parked values
        step; rst = 1'b1;
        step; rst = 1'b0; settle;
        chk("R1 b1 cleared", b1_out, 12'h000);
        chk("R1 b2 cleared", b2_out, 12'h000);
        chk("R1 a cleared", a_out, 12'h000);
        repeat (3) step;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule